// File: doc/BRIEF.md
# Reset-Gated Two-Wire Byte Memory

This block is a 256-byte memory that answers as a slave on a two-wire serial bus with one clock line and one data line. Both lines are sampled on the system clock. The block finds START and STOP conditions and compares the 7-bit device address. It acknowledges by pulling the data line low, stores one byte for each write transaction, and returns bytes in sequence on reads. It drives the bus only through a pull-down enable. The pad logic outside the block turns that enable into an open-drain output.

A system-level reset input has control over the bus. While that input is high, the block drops any transaction in progress, releases the data line, and ignores every new START. A store that is already inside its internal write cycle is protected from this reset and runs to the end. A write-protect input stops every store, but the block still acknowledges the bytes on the bus.

A write transaction is the address byte with R/W = 0, then the word-address byte, then one data byte. The store starts at the STOP that follows the data byte. A write transaction that ends after the word-address byte only loads the address pointer, so it can be followed by a repeated START and a read.

Top module: `i2c_gated_mem`

## Requirements
- R1: The block pulls SDA low during the ninth SCL pulse after the address byte only when bits 7..1 of that byte equal DEV_ADDR (default 7'b1010000). On any other address it never pulls SDA before the next START.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Before the first START, bus activity never makes the block pull SDA.
- R3: Bit 0 of the address byte selects the direction: 0 for write, 1 for read. In a write, the block acknowledges the word-address byte and the data byte. At the next STOP the data byte is stored at the word address, and the pointer becomes word address + 1. Further data bytes in the same transaction are not acknowledged.
- R4: busy_o goes high on the clock edge that acts on the STOP that commits a store. It stays high for exactly WRITE_CYCLES clock cycles.
- R5: While busy_o is high, the block does not acknowledge its own address.
- R6: A read returns the byte at the pointer and then increments the pointer. The pointer wraps from 255 to 0. Each master ACK (SDA low in the ninth pulse) loads the next byte.
- R7: After a master NACK (SDA high in the ninth pulse), the block leaves SDA released until the next START.
- R8: While sys_rst_i is high, sda_pull_o is low from the next edge on, and any transaction in progress is dropped. A START is ignored, and a STOP commits no store.
- R9: A store whose write cycle has already begun keeps its full busy_o length and its stored data even if sys_rst_i is high during the cycle.
- R10: While wp_i is high, a write transaction is still acknowledged, but its STOP leaves the memory unchanged, does not raise busy_o, and still advances the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the memory and the control logic |
| sys_rst_i | input | 1 | System reset condition; active high; gates the bus |
| wp_i | input | 1 | Write protect; active high |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | When high, the pad pulls SDA low |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
The bench exercises the decoder with several kinds of traffic:
- Clocked bits with no START, which tell apart a slave that waits for a START from one that reacts to any traffic.
- A foreign address and its own address while a store is in progress, which separate the address match from the busy lockout.
- A random read that runs from 0xFE across the top of the array, which shows whether the pointer wraps.
- Clock pulses after a master NACK, which show whether the block releases SDA.
- Stores done with wp_i high, and stores cut by sys_rst_i before and after their STOP, which tell aborting a transaction apart from finishing a write cycle that has started.

A behavioural model of busy_o is compared on every clock.

// File: rtl/i2cg_pkg.sv
package i2cg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_WORD,
    ST_DATA,
    ST_READ,
    ST_SKIP
  } i2cg_state_e;
endpackage

// File: rtl/i2cg_line_sync.sv
module i2cg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sq, sda_sq;
  logic scl_p, sda_p, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sq <= '1;
      sda_sq <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sq <= {scl_sq[STAGES-2:0], scl_i};
      sda_sq <= {sda_sq[STAGES-2:0], sda_i};
      scl_p  <= scl_sq[STAGES-1];
      sda_p  <= sda_sq[STAGES-1];
    end
  end

  assign scl_s      = scl_sq[STAGES-1];
  assign sda_s      = sda_sq[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  // SDA moving while SCL is held high marks a bus condition
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cg_wtimer.sv
module i2cg_wtimer #(
  parameter int CYCLES = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/i2cg_ctrl.sv
module i2cg_ctrl
  import i2cg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1010000,
  parameter int         AW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sys_rst_i,
  input  logic          wp_i,
  input  logic          busy_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] ptr_o,
  output logic          commit_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          pull_o
);
  i2cg_state_e   state_q;
  logic [3:0]    bit_cnt_q;
  logic [7:0]    sh_q, wdata_q;
  logic [AW-1:0] ptr_q, waddr_q;
  logic          in_ack_q, mack_q, pend_q, pull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      wdata_q   <= '0;
      ptr_q     <= '0;
      waddr_q   <= '0;
      in_ack_q  <= 1'b0;
      mack_q    <= 1'b0;
      pend_q    <= 1'b0;
      pull_q    <= 1'b0;
    end else if (sys_rst_i) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      pend_q    <= 1'b0;
      pull_q    <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_DEVADR;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      pend_q    <= 1'b0;
      pull_q    <= 1'b0;
    end else if (stop_i) begin
      state_q   <= ST_IDLE;
      in_ack_q  <= 1'b0;
      pend_q    <= 1'b0;
      pull_q    <= 1'b0;
    end else if (state_q != ST_IDLE) begin
      if (scl_rise_i) begin
        if (in_ack_q) begin
          // own ACK after a read address also reads back as low here
          if (state_q == ST_READ) mack_q <= ~sda_i;
        end else if (bit_cnt_q != 4'd8) begin
          if (state_q != ST_READ) sh_q <= {sh_q[6:0], sda_i};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end
      end else if (scl_fall_i) begin
        if (in_ack_q) begin
          in_ack_q  <= 1'b0;
          bit_cnt_q <= '0;
          pull_q    <= 1'b0;
          if (state_q == ST_READ) begin
            if (mack_q) begin
              sh_q   <= rd_data_i;
              ptr_q  <= ptr_q + 1'b1;
              pull_q <= ~rd_data_i[7];
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end else if (bit_cnt_q == 4'd8 && state_q != ST_SKIP) begin
          in_ack_q <= 1'b1;
          case (state_q)
            ST_DEVADR: begin
              if (sh_q[7:1] == DEV_ADDR && !busy_i) begin
                pull_q  <= 1'b1;
                mack_q  <= 1'b1;
                state_q <= sh_q[0] ? ST_READ : ST_WORD;
              end else begin
                state_q <= ST_SKIP;
              end
            end
            ST_WORD: begin
              pull_q  <= 1'b1;
              ptr_q   <= sh_q[AW-1:0];
              waddr_q <= sh_q[AW-1:0];
              state_q <= ST_DATA;
            end
            ST_DATA: begin
              pull_q  <= 1'b1;
              wdata_q <= sh_q;
              pend_q  <= 1'b1;
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_SKIP;
            end
            ST_READ: begin
              pull_q <= 1'b0;
              mack_q <= 1'b0;
            end
            default: ;
          endcase
        end else if (state_q == ST_READ && bit_cnt_q != 4'd0) begin
          sh_q   <= {sh_q[6:0], 1'b0};
          pull_q <= ~sh_q[6];
        end
      end
    end
  end

  assign commit_o  = stop_i & pend_q & ~wp_i & ~sys_rst_i;
  assign wr_addr_o = waddr_q;
  assign wr_data_o = wdata_q;
  assign ptr_o     = ptr_q;
  assign pull_o    = pull_q;
endmodule

// File: rtl/i2c_gated_mem.sv
module i2c_gated_mem #(
  parameter logic [6:0] DEV_ADDR     = 7'b1010000,
  parameter int         MEM_BYTES    = 256,
  parameter int         WRITE_CYCLES = 250000,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_i,
  input  logic wp_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o,
  output logic busy_o
);
  localparam int AW = $clog2(MEM_BYTES);

  logic          sda_s, scl_rise, scl_fall, start_c, stop_c, commit;
  logic [AW-1:0] ptr, wr_addr;
  logic [7:0]    wr_data, rd_data;
  logic [7:0]    mem_q [MEM_BYTES];

  i2cg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  i2cg_ctrl #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_i(sys_rst_i), .wp_i(wp_i),
    .busy_i(busy_o), .sda_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start_c), .stop_i(stop_c),
    .rd_data_i(rd_data), .ptr_o(ptr), .commit_o(commit),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .pull_o(sda_pull_o)
  );

  i2cg_wtimer #(.CYCLES(WRITE_CYCLES)) u_wtimer (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(commit), .busy_o(busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= '0;
    end else if (commit) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[ptr];
endmodule

// File: rtl/i2c_gated_mem_chk.sv
module i2c_gated_mem_chk #(
  parameter int WRITE_CYCLES = 250000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sys_rst_i,
  input logic wp_i,
  input logic sda_pull_o,
  input logic busy_o
);
  logic [31:0] run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_len <= '0;
    else if (busy_o) run_len <= run_len + 32'd1;
    else             run_len <= '0;
  end

  assert_release_in_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_i |=> !sda_pull_o);

  assert_no_store_in_reset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(sys_rst_i));

  assert_no_store_when_protected_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(wp_i));

  // R4 and R9: every busy window has its full length, reset or not
  assert_busy_length_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_len == 32'(WRITE_CYCLES));
endmodule

bind i2c_gated_mem i2c_gated_mem_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sys_rst_i(sys_rst_i), .wp_i(wp_i),
  .sda_pull_o(sda_pull_o), .busy_o(busy_o)
);

// File: tb/i2c_gated_mem_bench.sv
module i2c_gated_mem_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WC = 300;
  localparam int Q = 4;
  localparam int LAT = 3;
  localparam logic [6:0] DEV = 7'b1010000;

  logic clk = 1'b0, rst_n = 1'b0, sys_rst = 1'b0, wp = 1'b0;
  logic scl = 1'b1, msda = 1'b1;
  logic sda_pull, busy, sda_line;

  int checks = 0, errors = 0, cyc = 0, commit_cyc = -1, mcnt = 0;
  bit done = 0;
  logic [7:0] mm [256];

  assign sda_line = msda & ~sda_pull;

  i2c_gated_mem #(.DEV_ADDR(DEV), .WRITE_CYCLES(WC)) u_i2c_gated_mem (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_i(sys_rst), .wp_i(wp),
    .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull), .busy_o(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == commit_cyc) mcnt = WC;
    else if (mcnt > 0) mcnt = mcnt - 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R4 R9: per-clock busy model
  always @(negedge clk) if (rst_n && !done) chk("R4", int'(busy), int'(mcnt > 0));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_tx(input logic b, output logic got);
    tick(Q); msda = b;
    tick(Q); scl = 1'b1;
    tick(Q); got = sda_line;
    tick(Q); scl = 1'b0;
  endtask

  task automatic do_start();
    tick(Q); msda = 1'b1;
    tick(Q); scl = 1'b1;
    tick(Q); msda = 1'b0;
    tick(Q); scl = 1'b0;
  endtask

  task automatic do_stop(input bit commit, input logic [7:0] a, input logic [7:0] d);
    tick(Q); msda = 1'b0;
    tick(Q); scl = 1'b1;
    tick(Q); msda = 1'b1;
    if (commit) begin
      commit_cyc = cyc + LAT;
      mm[a] = d;
    end
    tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic acked);
    logic g;
    for (int i = 7; i >= 0; i--) bit_tx(v[i], g);
    bit_tx(1'b1, g);
    acked = ~g;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] v);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      bit_tx(1'b1, g);
      v[i] = g;
    end
    bit_tx(~give_ack, g);
  endtask

  task automatic write_one(input logic [7:0] a, input logic [7:0] d, input bit commit);
    logic k;
    do_start();
    wr_byte({DEV, 1'b0}, k); chk("R1", k, 1);
    wr_byte(a, k);           chk("R3", k, 1);
    wr_byte(d, k);           chk("R3", k, 1);
    do_stop(commit, a, d);
  endtask

  task automatic set_ptr_and_read(input logic [7:0] a, input int n);
    logic k;
    logic [7:0] v;
    do_start();
    wr_byte({DEV, 1'b0}, k); chk("R1", k, 1);
    wr_byte(a, k);           chk("R3", k, 1);
    do_start();
    wr_byte({DEV, 1'b1}, k); chk("R1", k, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(i != n - 1, v);
      chk("R6", v, mm[8'(a + i)]);
    end
    do_stop(0, 8'h00, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic k, g;
    logic [7:0] v;
    for (int i = 0; i < 256; i++) mm[i] = 8'h00;
    tick(3);
    chk("R2", sda_pull, 0);
    chk("R4", busy, 0);
    rst_n = 1'b1;
    tick(2);
    scl = 1'b0;

    // R2: clocked traffic with no START gets no answer
    wr_byte({DEV, 1'b0}, k); chk("R2", k, 0);
    wr_byte(8'h10, k);       chk("R2", k, 0);

    // R1: foreign address
    do_start();
    wr_byte({7'b1010010, 1'b0}, k); chk("R1", k, 0);
    wr_byte(8'h33, k);              chk("R1", k, 0);
    do_stop(0, 8'h00, 8'h00);

    // R3: store, then R5: own address refused while busy
    write_one(8'h10, 8'h5A, 1);
    do_start();
    wr_byte({DEV, 1'b0}, k); chk("R5", k, 0);
    do_stop(0, 8'h00, 8'h00);
    tick(WC);

    // R3: second data byte not acknowledged, only first stored
    do_start();
    wr_byte({DEV, 1'b0}, k); chk("R1", k, 1);
    wr_byte(8'hFF, k);       chk("R3", k, 1);
    wr_byte(8'hC3, k);       chk("R3", k, 1);
    wr_byte(8'hEE, k);       chk("R3", k, 0);
    do_stop(1, 8'hFF, 8'hC3);
    tick(WC);

    // R6: sequential read across the top of the array
    set_ptr_and_read(8'hFE, 3);
    // current-address read: pointer is now 0x01
    do_start();
    wr_byte({DEV, 1'b1}, k); chk("R1", k, 1);
    rd_byte(1'b0, v);        chk("R6", v, mm[8'h01]);
    // R7: after NACK the line stays released
    bit_tx(1'b1, g); chk("R7", g, 1);
    bit_tx(1'b1, g); chk("R7", g, 1);
    do_stop(0, 8'h00, 8'h00);
    set_ptr_and_read(8'h10, 1);

    // R10: protected write acknowledged, nothing stored, pointer moves on
    wp = 1'b1;
    write_one(8'h20, 8'h77, 0);
    tick(20);
    wp = 1'b0;
    do_start();
    wr_byte({DEV, 1'b1}, k); chk("R10", k, 1);
    rd_byte(1'b0, v);        chk("R10", v, 8'h00);
    do_stop(0, 8'h00, 8'h00);
    set_ptr_and_read(8'h20, 1);

    // R8: reset in the middle of the data byte
    do_start();
    wr_byte({DEV, 1'b0}, k); chk("R8", k, 1);
    wr_byte(8'h30, k);       chk("R8", k, 1);
    for (int i = 0; i < 4; i++) bit_tx(1'b0, g);
    sys_rst = 1'b1;
    tick(2);
    chk("R8", sda_pull, 0);
    do_start();
    wr_byte({DEV, 1'b0}, k); chk("R8", k, 0);
    wr_byte(8'h30, k);       chk("R8", k, 0);
    do_stop(0, 8'h00, 8'h00);
    sys_rst = 1'b0;
    tick(4);
    set_ptr_and_read(8'h30, 1);

    // R9: reset while a store is in its write cycle
    write_one(8'h40, 8'h99, 1);
    tick(20);
    chk("R9", busy, 1);
    sys_rst = 1'b1;
    tick(50);
    chk("R9", busy, 1);
    sys_rst = 1'b0;
    tick(WC);
    chk("R9", busy, 0);
    set_ptr_and_read(8'h40, 1);

    tick(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule